// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block drives a register bus that uses three wires: a clock, an active-low enable and one data line that both ends share. A host presents a 9-bit command word and, for a write, a 16-bit value, and then pulses `start` for one cycle. The block then runs exactly one framed transaction and pulses `done`. After a read it holds the 16 bits it sampled on `rdata`.

Every frame is wrapped in extra clock pulses that are sent while the enable is high. Two of these pulses come before the enable falls and one comes after it rises again. Inside the enable window the block shifts out the 9-bit header, most significant bit first. Bit 7 of the command word selects the direction: 1 means read and 0 means write. Bit 8 has no meaning to the target, and bits 6..0 carry the register address. On a write the block then drives 16 data bits. On a read it releases the data line, sends one turnaround pulse and then samples 16 bits. The data pin is split into `sdo`, `sdo_oe` and `sdi` so that a pad cell can be placed at the chip edge. The width of each clock phase is set by a parameter, counted in system clock cycles.

Top module: `three_wire_master`

## Requirements
- R1: When idle, and after reset, `en_n`=1, `sclk`=0, `sdo_oe`=1, `sdo`=0, `busy`=0 and `done`=0.
- R2: After an accepted `start`, exactly two full `sclk` pulses occur with `en_n`=1 before `en_n` goes to 0.
- R3: While `en_n`=0, the first 9 rising edges of `sclk` carry `cmd[8:0]` on `sdo`, MSB first, with `sdo_oe`=1. `cmd[7]`=1 selects a read.
- R4: On a write, the next 16 rising edges carry `wdata[15:0]` MSB first with `sdo_oe`=1. The enable window holds exactly 25 pulses.
- R5: On a read, `sdo_oe` is 0 from the 10th pulse of the window onward. The 10th pulse is a turnaround. Pulses 11..26 sample `sdi` MSB first while `sclk` is high, and `rdata` then equals the sampled word. The window holds exactly 26 pulses.
- R6: After `en_n` returns to 1, exactly one more `sclk` pulse follows, with `sdo_oe`=1 and `sdo`=0.
- R7: Each `sclk` pulse is low for `LO_CYC` cycles and then high for `HI_CYC` cycles. `done` is observed N*(LO_CYC+HI_CYC) cycles after the clock edge that accepts `start`, where N=28 for a write and N=29 for a read.
- R8: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance until that cycle.
- R9: A `start` raised while `busy`=1 is ignored. The frame in flight keeps its header, data and length, and no second frame follows.
- R10: A write transaction leaves `rdata` unchanged. `rdata` holds its value until the next read completes.
- R11: `en_n` changes only while `sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a transaction |
| cmd | input | 9 | Header word: don't-care, direction (bit 7), 7-bit address |
| wdata | input | 16 | Value sent on a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 16 | Last word read from the target |
| sclk | output | 1 | Serial clock |
| en_n | output | 1 | Active-low frame enable |
| sdo | output | 1 | Data line drive value |
| sdo_oe | output | 1 | Data line drive enable |
| sdi | input | 1 | Data line sampled value |

## Verification
The bench models the target from the pin side. It counts pulses outside the enable window, which exposes a design that drops a guard pulse before the frame or the trailing one after it. A read without its turnaround pulse shifts the returned word by one bit, and a design that keeps driving the line on a read is caught by the drive-enable check at each data edge. Commands that set the don't-care bit with either direction show whether the direction is decoded from the wrong position. A second `start` in mid-frame shows whether a design restarts or reloads its shifter. A write that follows a read shows whether the stale capture leaks into `rdata`.

// File: rtl/twm_pkg.sv
package twm_pkg;
   typedef enum logic [2:0] {
      SEG_IDLE,
      SEG_PRE,
      SEG_HDR,
      SEG_TURN,
      SEG_DATA,
      SEG_POST
   } twm_seg_e;
endpackage

// File: rtl/twm_phase_timer.sv
module twm_phase_timer #(
   parameter int LO_CYC = 2,
   parameter int HI_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic pulse_end
);
   localparam int PER = LO_CYC + HI_CYC;
   localparam int PW  = (PER > 2) ? $clog2(PER) : 1;

   if (LO_CYC < 1) begin : g_lo_chk
      $error("twm_phase_timer: LO_CYC must be at least 1");
   end
   if (HI_CYC < 1) begin : g_hi_chk
      $error("twm_phase_timer: HI_CYC must be at least 1");
   end

   if (PER == 2) begin : g_toggle
      logic high_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   high_q <= 1'b0;
         else if (!run) high_q <= 1'b0;
         else          high_q <= ~high_q;
      end
      assign sclk      = run & high_q;
      assign pulse_end = run & high_q;
   end else begin : g_count
      logic [PW-1:0] ph_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     ph_q <= '0;
         else if (!run)                  ph_q <= '0;
         else if (ph_q == PW'(PER - 1))  ph_q <= '0;
         else                            ph_q <= ph_q + PW'(1);
      end
      assign sclk      = run && (ph_q >= PW'(LO_CYC));
      assign pulse_end = run && (ph_q == PW'(PER - 1));
   end

   // R7: a pulse always ends on its high phase
   a_r7_end_high: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_end |-> sclk);
   // R7: the clock is low in the cycle after a pulse ends
   a_r7_low_after: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_end |=> !sclk);
endmodule

// File: rtl/twm_frame_seq.sv
module twm_frame_seq
   import twm_pkg::*;
#(
   parameter int PRE_PULSES  = 2,
   parameter int CMD_W       = 9,
   parameter int DAT_W       = 16,
   parameter int POST_PULSES = 1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     pulse_end,
   input  logic     is_rd,
   output twm_seg_e seg,
   output logic     last_pulse
);
   localparam int MAX_PULSES = PRE_PULSES + CMD_W + 1 + DAT_W + POST_PULSES;
   localparam int IW         = $clog2(MAX_PULSES + 1);
   localparam int HDR_BEG    = PRE_PULSES;
   localparam int HDR_END    = HDR_BEG + CMD_W;

   if (PRE_PULSES < 0 || POST_PULSES < 1) begin : g_guard_chk
      $error("twm_frame_seq: need POST_PULSES >= 1 and PRE_PULSES >= 0");
   end
   if (CMD_W < 2 || DAT_W < 1) begin : g_width_chk
      $error("twm_frame_seq: field widths too small");
   end

   logic [IW-1:0] pidx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pidx_q <= '0;
      else if (!run)      pidx_q <= '0;
      else if (pulse_end) pidx_q <= pidx_q + IW'(1);
   end

   int p, dat_beg, post_beg, last_idx;
   always_comb begin
      p        = int'(pidx_q);
      dat_beg  = HDR_END + (is_rd ? 1 : 0);
      post_beg = dat_beg + DAT_W;
      last_idx = post_beg + POST_PULSES - 1;
      if (!run)                              seg = SEG_IDLE;
      else if (p < HDR_BEG)                  seg = SEG_PRE;
      else if (p < HDR_END)                  seg = SEG_HDR;
      else if (p < dat_beg)                  seg = SEG_TURN;
      else if (p < post_beg)                 seg = SEG_DATA;
      else                                   seg = SEG_POST;
      last_pulse = run && (p == last_idx);
   end

   // R2: the pulse index never runs past the end of the longest frame
   a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (int'(pidx_q) <= MAX_PULSES - 1));
   // R5: a turnaround segment exists only on reads
   a_r5_turn_read: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_TURN) |-> is_rd);
endmodule

// File: rtl/twm_shifter.sv
module twm_shifter #(
   parameter int CMD_W = 9,
   parameter int DAT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CMD_W-1:0] cmd,
   input  logic [DAT_W-1:0] wdata,
   input  logic             tx_shift,
   input  logic             rx_shift,
   input  logic             sdi,
   output logic             tx_bit,
   output logic [DAT_W-1:0] rx_word
);
   localparam int TW = CMD_W + DAT_W;

   logic [TW-1:0]    tx_q;
   logic [DAT_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q <= '0;
      else if (load)     tx_q <= {cmd, wdata};
      else if (tx_shift) tx_q <= {tx_q[TW-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_q <= '0;
      else if (load)     rx_q <= '0;
      else if (rx_shift) rx_q <= {rx_q[DAT_W-2:0], sdi};
   end

   assign tx_bit  = tx_q[TW-1];
   assign rx_word = rx_q;

   // R9: the transmit register is never loaded and shifted in the same cycle
   a_r9_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && (tx_shift || rx_shift)));
endmodule

// File: rtl/three_wire_master.sv
module three_wire_master
   import twm_pkg::*;
#(
   parameter int CMD_W       = 9,
   parameter int DAT_W       = 16,
   parameter int RD_BIT      = 7,
   parameter int PRE_PULSES  = 2,
   parameter int POST_PULSES = 1,
   parameter int LO_CYC      = 2,
   parameter int HI_CYC      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] cmd,
   input  logic [DAT_W-1:0] wdata,
   output logic             busy,
   output logic             done,
   output logic [DAT_W-1:0] rdata,
   output logic             sclk,
   output logic             en_n,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic             sdi
);
   if (RD_BIT < 0 || RD_BIT >= CMD_W) begin : g_rdbit_chk
      $error("three_wire_master: RD_BIT outside command word");
   end

   logic     busy_q, done_q, rd_q;
   logic     accept, pulse_end, last_pulse, tx_bit;
   logic     drive_seg, rx_seg, frame_end;
   twm_seg_e seg;
   logic [DAT_W-1:0] rx_word, rdata_q;

   assign accept    = start && !busy_q;
   assign frame_end = pulse_end && last_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         done_q <= frame_end;
         if (accept) begin
            busy_q <= 1'b1;
            rd_q   <= cmd[RD_BIT];
         end else if (frame_end) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (frame_end && rd_q) rdata_q <= rx_word;
   end

   twm_phase_timer #(
      .LO_CYC (LO_CYC),
      .HI_CYC (HI_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .sclk      (sclk),
      .pulse_end (pulse_end)
   );

   twm_frame_seq #(
      .PRE_PULSES  (PRE_PULSES),
      .CMD_W       (CMD_W),
      .DAT_W       (DAT_W),
      .POST_PULSES (POST_PULSES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy_q),
      .pulse_end  (pulse_end),
      .is_rd      (rd_q),
      .seg        (seg),
      .last_pulse (last_pulse)
   );

   assign drive_seg = (seg == SEG_HDR) || ((seg == SEG_DATA) && !rd_q);
   assign rx_seg    = (seg == SEG_DATA) && rd_q;

   twm_shifter #(
      .CMD_W (CMD_W),
      .DAT_W (DAT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .cmd      (cmd),
      .wdata    (wdata),
      .tx_shift (pulse_end && drive_seg),
      .rx_shift (pulse_end && rx_seg),
      .sdi      (sdi),
      .tx_bit   (tx_bit),
      .rx_word  (rx_word)
   );

   assign en_n   = !((seg == SEG_HDR) || (seg == SEG_TURN) || (seg == SEG_DATA));
   assign sdo_oe = !(rd_q && ((seg == SEG_TURN) || (seg == SEG_DATA)));
   assign sdo    = drive_seg ? tx_bit : 1'b0;
   assign busy   = busy_q;
   assign done   = done_q;
   assign rdata  = rdata_q;

   // R1: idle pin levels
   a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (en_n && !sclk && sdo_oe && !sdo));
   // R8: done lasts a single cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: the line is released only inside the enable window
   a_r5_release_window: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !en_n);
   // R11: enable moves only while the clock is low
   a_r11_en_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_n) |-> !sclk);
   // R10: rdata changes only on the completion of a read
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata) |-> (done && rd_q));
endmodule

// File: tb/three_wire_master_test.sv
module three_wire_master_test;
   localparam int LO = 2;
   localparam int HI = 3;
   localparam int P  = LO + HI;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [8:0]  cmd = '0;
   logic [15:0] wdata = '0;
   logic        busy, done, sclk, en_n, sdo, sdo_oe, sdi;
   logic [15:0] rdata;

   always #2 clk = ~clk;

   three_wire_master #(.LO_CYC(LO), .HI_CYC(HI)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wdata(wdata),
      .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .en_n(en_n),
      .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
   );

   int checks = 0;
   int failures = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // target model
   int          fcnt = 0, pre_cnt = 0, post_cnt = 0, oe_bad = 0, post_bad = 0, en_bad = 0;
   logic [8:0]  hcap = '0;
   logic [15:0] wcap = '0;
   logic [15:0] tgt_val = '0;
   bit          rd_mode = 1'b0;

   assign sdi = (rd_mode && fcnt >= 11 && fcnt <= 26) ? tgt_val[26 - fcnt] : 1'b0;

   always @(posedge sclk) begin
      if (!en_n) begin
         fcnt = fcnt + 1;
         if (fcnt <= 9) begin
            hcap = {hcap[7:0], sdo};
            if (!sdo_oe) oe_bad++;
         end else if (!rd_mode) begin
            if (fcnt <= 25) wcap = {wcap[14:0], sdo};
            if (!sdo_oe) oe_bad++;
         end else if (sdo_oe) begin
            oe_bad++;
         end
      end else if (fcnt == 0) begin
         pre_cnt++;
      end else begin
         post_cnt++;
         if (!sdo_oe || sdo) post_bad++;
      end
   end

   always @(en_n) if (sclk) en_bad++;

   task automatic clear_target(input bit rd, input logic [15:0] v);
      fcnt = 0; pre_cnt = 0; post_cnt = 0; oe_bad = 0; post_bad = 0;
      hcap = '0; wcap = '0; rd_mode = rd; tgt_val = v;
   endtask

   // {cmd, wdata, target value}
   localparam logic [40:0] VEC [6] = '{
      {9'h005, 16'hA5C3, 16'h1234},
      {9'h085, 16'h0000, 16'hBEEF},
      {9'h17F, 16'hFFFF, 16'h5555},
      {9'h1FF, 16'h1111, 16'h8001},
      {9'h000, 16'h0000, 16'hFFFF},
      {9'h0C0, 16'h7E7E, 16'h0000}
   };

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] last_rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(en_n && !sclk && sdo_oe && !sdo && !busy && !done, "R1 reset pins",
            {en_n, sclk, sdo_oe, sdo, busy, done}, 6'b101000);
      check(rdata == 16'h0, "R1 reset rdata", rdata, 0);
      last_rd = 16'h0;

      for (int i = 0; i < 6; i++) begin
         logic [8:0]  c;
         logic [15:0] w, v;
         bit          rd;
         int          cyc, expn;
         {c, w, v} = VEC[i];
         rd = c[7];
         clear_target(rd, v);
         cmd = c; wdata = w; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc = 1;
         check(busy == 1'b1, "R8 busy after start", busy, 1);
         while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
         end
         expn = rd ? 29 : 28;
         check(cyc == expn * P + 1, "R7 duration", cyc, expn * P + 1);
         check(pre_cnt == 2, "R2 pre pulses", pre_cnt, 2);
         check(hcap == c, "R3 header", hcap, c);
         check(post_cnt == 1 && post_bad == 0, "R6 post pulse", post_cnt, 1);
         check(oe_bad == 0, rd ? "R5 line release" : "R4 line drive", oe_bad, 0);
         if (rd) begin
            check(fcnt == 26, "R5 window length", fcnt, 26);
            check(rdata == v, "R5 read data", rdata, v);
            last_rd = v;
         end else begin
            check(fcnt == 25, "R4 window length", fcnt, 25);
            check(wcap == w, "R4 write data", wcap, w);
            check(rdata == last_rd, "R10 rdata kept on write", rdata, last_rd);
         end
         @(negedge clk);
         check(!done && !busy, "R8 done single cycle", {done, busy}, 0);
         check(en_n && !sclk && sdo_oe && !sdo, "R1 idle after frame",
               {en_n, sclk, sdo_oe, sdo}, 4'b1010);
         repeat (3) @(negedge clk);
         check(rdata == last_rd, "R10 rdata held idle", rdata, last_rd);
      end

      // R9: second start in mid-frame is ignored
      begin
         int cyc;
         clear_target(1'b0, 16'h0);
         cmd = 9'h02A; wdata = 16'hC33C; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         cyc = 1;
         repeat (20) begin @(negedge clk); cyc++; end
         cmd = 9'h0FF; wdata = 16'h0000; start = 1'b1;
         @(negedge clk); cyc++;
         start = 1'b0;
         while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
         end
         check(cyc == 28 * P + 1, "R9 duration unchanged", cyc, 28 * P + 1);
         check(hcap == 9'h02A, "R9 header unchanged", hcap, 9'h02A);
         check(wcap == 16'hC33C, "R9 data unchanged", wcap, 16'hC33C);
         repeat (40) @(negedge clk);
         check(pre_cnt == 2 && post_cnt == 1 && !busy, "R9 no second frame",
               pre_cnt + post_cnt, 3);
      end

      check(en_bad == 0, "R11 enable moved with clock high", en_bad, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule